// File: doc/BRIEF.md
# Linked-descriptor DMA channel

This block is one DMA channel that takes its whole job from memory. Software stores a six-word descriptor in memory and writes its address into the channel. It then sets the run bit. The channel reads the descriptor through its memory port and copies the number of bytes that the descriptor gives. It uses the element width, burst length, addressing mode and request kind that the descriptor's config word selects for each side. It then follows the descriptor's next pointer. When the next pointer holds the end marker, the channel stops by itself.

Descriptor fetches, data reads and data writes all share one 32-bit, word-addressed memory port with a request/grant handshake. Read data returns on a separate valid strobe. Status outputs give the live source address, destination address and remaining byte count. A one-cycle pulse marks the end of each descriptor.

Top module: `dlc_chan_top`

## Requirements
- R1: After reset, `run_o`, `mem_req` and `pkg_done` are low, and `cur_src_o`, `cur_dst_o` and `bytes_left_o` read zero.
- R2: A register write with `ctl_sel`=1 sets the descriptor address. A write with `ctl_sel`=0 and `ctl_wdata[0]`=1 while idle raises `run_o` and starts the channel. The channel then reads six words from consecutive word addresses starting at the descriptor address. The words are, in order: config, source address, destination address, byte count, parameter, next pointer.
- R3: Config word fields. For the destination: width code in bits 26:25, burst code in 23:22, hold-address bit in 21, request kind in 20:16. For the source: width code in 10:9, burst code in 7:6, hold-address bit in 5, request kind in 4:0. Width codes 0/1/2/3 mean 1/2/4/8 bytes, and 8 bytes is carried as 4. Burst codes 0/1/2/3 mean 1/4/8/16 beats. Each beat moves the smaller of the two element sizes. A burst is the smaller of the two burst lengths.
- R4: With the hold-address bit at 0, a side's address advances by the bytes of each beat. With it at 1, the address stays where it started.
- R5: Each beat reads the aligned word that holds the source address. It writes the aligned word that holds the destination address. The data moves from the source byte lane to the destination byte lane, and `mem_be` covers exactly the bytes moved. Every request address is word aligned.
- R6: When fewer bytes remain than one element, the last beat moves only those bytes. `bytes_left_o` falls by the number of set `mem_be` bits on every accepted write.
- R7: Let W be parameter word bits 7:0, and assume memory that always grants. Within a burst, the next read is accepted one clock after the previous write is accepted. Between bursts, the gap is W+2 clocks. No gap follows the last beat.
- R8: A side whose request kind is nonzero starts each burst only while its ready input (`src_rdy` or `dst_rdy`) is high. Descriptor fetches are not gated.
- R9: `pkg_done` is high for exactly one clock after each descriptor completes. A byte count of zero completes with no data access.
- R10: After a descriptor, a next pointer other than 32'hFFFFF800 starts a fetch at that address. The value 32'hFFFFF800 drops `run_o` and leaves the channel idle.
- R11: A write of 0 to bit 0 with `ctl_sel`=0 stops the channel. In the next cycle `run_o` and `mem_req` are low, and no further access or `pkg_done` follows.
- R12: A request that is not granted stays asserted with the same address and direction. Only one access is outstanding, so stalls lose or repeat no data.
- R13: The status outputs track progress. The distance travelled by the source address and by the destination address (both in linear mode) each equal the byte count minus `bytes_left_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Register write strobe |
| ctl_sel | input | 1 | 0: run bit register, 1: descriptor address register |
| ctl_wdata | input | 32 | Register write data |
| src_rdy | input | 1 | Source side ready, used when the source request kind is nonzero |
| dst_rdy | input | 1 | Destination side ready, used when the destination request kind is nonzero |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Write data, lane aligned |
| mem_be | output | 4 | Write byte enables |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| pkg_done | output | 1 | One-cycle pulse per completed descriptor |
| run_o | output | 1 | Run bit readback |
| cur_src_o | output | 32 | Current source address |
| cur_dst_o | output | 32 | Current destination address |
| bytes_left_o | output | 32 | Remaining byte count |

## Verification
The bench targets byte-lane moves between unaligned source and destination addresses. A wrong shift would corrupt neighbouring bytes or land data in the wrong lane. It also targets a final partial beat, where bad enables would overwrite bytes past the end, and a held destination address, which would otherwise spray a whole buffer. Burst gaps are timed to the clock, so a timer that is off by one, or that also waits after the last beat, shows up as a wrong gap. A zero-length descriptor chained to a real one checks that no stray access happens and that the chain is followed. The bench also checks a stop in mid-transfer, gating on a ready input, and a memory that grants only one cycle in three, where a dropped or repeated request would change the data or the access counts.

// File: rtl/dlc_pkg.sv
`timescale 1ns/1ps
package dlc_pkg;
  localparam int WORD_W     = 32;
  localparam int LANES      = WORD_W / 8;
  localparam int DESC_WORDS = 6;
  localparam logic [WORD_W-1:0] CHAIN_END = 32'hFFFF_F800;

  // word order inside a descriptor (fetch order matters)
  localparam int IX_CFG  = 0;
  localparam int IX_SRC  = 1;
  localparam int IX_DST  = 2;
  localparam int IX_CNT  = 3;
  localparam int IX_PARM = 4;
  localparam int IX_NEXT = 5;

  typedef enum logic [3:0] {
    ST_IDLE, ST_FETCH_REQ, ST_FETCH_RSP, ST_SETUP, ST_GATE,
    ST_RD_REQ, ST_RD_RSP, ST_WR_REQ, ST_GAP, ST_DONE
  } eng_state_t;

  typedef struct packed {
    logic [1:0] width_code;
    logic [1:0] burst_code;
    logic       hold_addr;
    logic [4:0] req_kind;
  } side_cfg_t;

  function automatic side_cfg_t unpack_dst(input logic [WORD_W-1:0] c);
    return {c[26:25], c[23:22], c[21], c[20:16]};
  endfunction

  function automatic side_cfg_t unpack_src(input logic [WORD_W-1:0] c);
    return {c[10:9], c[7:6], c[5], c[4:0]};
  endfunction

  // element size in bytes; the 64-bit code is carried on a 32-bit port
  function automatic logic [2:0] unit_bytes(input logic [1:0] code);
    case (code)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [4:0] burst_len(input logic [1:0] code);
    case (code)
      2'd0:    return 5'd1;
      2'd1:    return 5'd4;
      2'd2:    return 5'd8;
      default: return 5'd16;
    endcase
  endfunction

  function automatic logic [2:0] min_bytes(input logic [2:0] a, input logic [2:0] b);
    return (a < b) ? a : b;
  endfunction

  function automatic logic [4:0] min_beats(input logic [4:0] a, input logic [4:0] b);
    return (a < b) ? a : b;
  endfunction

  // bytes moved by the coming beat
  function automatic logic [2:0] beat_size(input logic [2:0] elem, input logic [WORD_W-1:0] left);
    return (left < WORD_W'(elem)) ? left[2:0] : elem;
  endfunction

  function automatic logic [WORD_W-1:0] lane_shift(input logic [WORD_W-1:0] w,
                                                   input logic [1:0] from_l,
                                                   input logic [1:0] to_l);
    logic [WORD_W-1:0] t;
    t = w >> {from_l, 3'b000};
    return t << {to_l, 3'b000};
  endfunction

  function automatic logic [LANES-1:0] lane_strobe(input logic [2:0] n, input logic [1:0] at);
    logic [2*LANES-1:0] m;
    m = {LANES'(0), LANES'((5'd1 << n) - 5'd1)};
    m = m << at;
    return m[LANES-1:0];
  endfunction
endpackage

// File: rtl/dlc_ctrl.sv
`timescale 1ns/1ps
module dlc_ctrl #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic          sel,
  input  logic [AW-1:0] wdata,
  input  logic          finish,
  output logic          run,
  output logic          start_evt,
  output logic          stop_evt,
  output logic [AW-1:0] base_addr
);
  logic run_write;

  assign run_write = we && !sel;
  assign start_evt = run_write && wdata[0] && !run;
  assign stop_evt  = run_write && !wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run       <= 1'b0;
      base_addr <= '0;
    end else begin
      if (we && sel) base_addr <= {wdata[AW-1:2], 2'b00};
      if (run_write)   run <= wdata[0];
      else if (finish) run <= 1'b0;
    end
  end

  assert_start_sets_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> run);
  assert_stop_clears_run_R11: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !run);
endmodule

// File: rtl/dlc_desc_store.sv
`timescale 1ns/1ps
module dlc_desc_store #(
  parameter int WORDS = 6,
  parameter int W     = 32,
  localparam int IW   = $clog2(WORDS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr,
  input  logic [IW-1:0]           idx,
  input  logic [W-1:0]            wdata,
  output logic [WORDS-1:0][W-1:0] words
);
  for (genvar g = 0; g < WORDS; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       words[g] <= '0;
      else if (wr && idx == IW'(g))     words[g] <= wdata;
    end
  end
endmodule

// File: rtl/dlc_gap_timer.sv
`timescale 1ns/1ps
module dlc_gap_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] val,
  input  logic         tick,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt <= '0;
    else if (load)                cnt <= val;
    else if (tick && cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expired = (cnt <= W'(1));
endmodule

// File: rtl/dlc_chan_top.sv
`timescale 1ns/1ps
module dlc_chan_top
  import dlc_pkg::*;
#(
  parameter int WAIT_W = 8,
  parameter int BEAT_W = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctl_we,
  input  logic        ctl_sel,
  input  logic [31:0] ctl_wdata,
  input  logic        src_rdy,
  input  logic        dst_rdy,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  output logic [3:0]  mem_be,
  input  logic        mem_gnt,
  input  logic        mem_rvalid,
  input  logic [31:0] mem_rdata,
  output logic        pkg_done,
  output logic        run_o,
  output logic [31:0] cur_src_o,
  output logic [31:0] cur_dst_o,
  output logic [31:0] bytes_left_o
);
  localparam int IDX_W = $clog2(DESC_WORDS);

  eng_state_t st;
  logic [WORD_W-1:0] ptr, src_a, dst_a, left, rbuf;
  logic [IDX_W-1:0]  idx;
  logic [BEAT_W-1:0] beat_no;
  logic [DESC_WORDS-1:0][WORD_W-1:0] dw;
  side_cfg_t s_cfg, d_cfg;
  logic [2:0] elem, nb;
  logic [4:0] blen;
  logic [WAIT_W-1:0] wait_val;

  // named events for assertions
  logic start_evt, stop_evt, finish_evt, base_unused;
  logic [WORD_W-1:0] base_addr;
  logic fetch_fire, rd_fire, wr_fire, fetch_last, last_beat, burst_end;
  logic chain_end, side_ready, gap_load, gap_tick, gap_expired, desc_wr;

  dlc_ctrl #(.AW(WORD_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .we(ctl_we), .sel(ctl_sel), .wdata(ctl_wdata),
    .finish(finish_evt), .run(run_o), .start_evt(start_evt), .stop_evt(stop_evt),
    .base_addr(base_addr)
  );

  dlc_desc_store #(.WORDS(DESC_WORDS), .W(WORD_W)) u_desc (
    .clk(clk), .rst_n(rst_n), .wr(desc_wr), .idx(idx), .wdata(mem_rdata), .words(dw)
  );

  dlc_gap_timer #(.W(WAIT_W)) u_gap (
    .clk(clk), .rst_n(rst_n), .load(gap_load), .val(wait_val), .tick(gap_tick),
    .expired(gap_expired)
  );

  assign base_unused = |base_addr[1:0];
  assign s_cfg    = unpack_src(dw[IX_CFG]);
  assign d_cfg    = unpack_dst(dw[IX_CFG]);
  assign elem     = min_bytes(unit_bytes(s_cfg.width_code), unit_bytes(d_cfg.width_code));
  assign blen     = min_beats(burst_len(s_cfg.burst_code), burst_len(d_cfg.burst_code));
  assign nb       = beat_size(elem, left);
  assign wait_val = dw[IX_PARM][WAIT_W-1:0];
  assign chain_end = (dw[IX_NEXT] == CHAIN_END);
  assign side_ready = (s_cfg.req_kind == 5'd0 || src_rdy) &&
                      (d_cfg.req_kind == 5'd0 || dst_rdy);

  // memory port
  assign mem_req = (st == ST_FETCH_REQ) || (st == ST_RD_REQ) || (st == ST_WR_REQ);
  assign mem_we  = (st == ST_WR_REQ);
  always_comb begin
    case (st)
      ST_FETCH_REQ: mem_addr = ptr + (WORD_W'(idx) << 2);
      ST_RD_REQ:    mem_addr = {src_a[WORD_W-1:2], 2'b00};
      ST_WR_REQ:    mem_addr = {dst_a[WORD_W-1:2], 2'b00};
      default:      mem_addr = '0;
    endcase
  end
  assign mem_wdata = lane_shift(rbuf, src_a[1:0], dst_a[1:0]);
  assign mem_be    = mem_we ? lane_strobe(nb, dst_a[1:0]) : {LANES{1'b1}};

  assign fetch_fire = (st == ST_FETCH_REQ) && mem_gnt;
  assign rd_fire    = (st == ST_RD_REQ) && mem_gnt;
  assign wr_fire    = (st == ST_WR_REQ) && mem_gnt;
  assign desc_wr    = (st == ST_FETCH_RSP) && mem_rvalid && !stop_evt;
  assign fetch_last = (idx == IDX_W'(DESC_WORDS - 1));
  assign last_beat  = (left == WORD_W'(nb));
  assign burst_end  = ((beat_no + 1'b1) == BEAT_W'(blen));
  assign gap_load   = wr_fire && !last_beat && burst_end && (wait_val != '0) && !stop_evt;
  assign gap_tick   = (st == ST_GAP);
  assign pkg_done   = (st == ST_DONE);
  assign finish_evt = (st == ST_DONE) && chain_end;

  assign cur_src_o    = src_a;
  assign cur_dst_o    = dst_a;
  assign bytes_left_o = left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      ptr     <= '0;
      src_a   <= '0;
      dst_a   <= '0;
      left    <= '0;
      rbuf    <= '0;
      idx     <= '0;
      beat_no <= '0;
    end else if (stop_evt) begin
      st <= ST_IDLE;
    end else begin
      case (st)
        ST_IDLE: if (start_evt) begin
          ptr <= base_addr;
          idx <= '0;
          st  <= ST_FETCH_REQ;
        end
        ST_FETCH_REQ: if (fetch_fire) st <= ST_FETCH_RSP;
        ST_FETCH_RSP: if (mem_rvalid) begin
          if (fetch_last) st <= ST_SETUP;
          else begin
            idx <= idx + 1'b1;
            st  <= ST_FETCH_REQ;
          end
        end
        ST_SETUP: begin
          src_a   <= dw[IX_SRC];
          dst_a   <= dw[IX_DST];
          left    <= dw[IX_CNT];
          beat_no <= '0;
          st      <= (dw[IX_CNT] == '0) ? ST_DONE : ST_GATE;
        end
        ST_GATE:   if (side_ready) st <= ST_RD_REQ;
        ST_RD_REQ: if (rd_fire) st <= ST_RD_RSP;
        ST_RD_RSP: if (mem_rvalid) begin
          rbuf <= mem_rdata;
          st   <= ST_WR_REQ;
        end
        ST_WR_REQ: if (wr_fire) begin
          left <= left - WORD_W'(nb);
          if (!s_cfg.hold_addr) src_a <= src_a + WORD_W'(nb);
          if (!d_cfg.hold_addr) dst_a <= dst_a + WORD_W'(nb);
          if (last_beat) st <= ST_DONE;
          else if (burst_end) begin
            beat_no <= '0;
            st      <= (wait_val != '0) ? ST_GAP : ST_GATE;
          end else begin
            beat_no <= beat_no + 1'b1;
            st      <= ST_RD_REQ;
          end
        end
        ST_GAP: if (gap_expired) st <= ST_GATE;
        ST_DONE: begin
          if (!chain_end) begin
            ptr <= dw[IX_NEXT];
            idx <= '0;
            st  <= ST_FETCH_REQ;
          end else st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // ---------------- assertions ----------------
  assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt && !stop_evt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  assert_word_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00));

  assert_left_tracks_be_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && !stop_evt) |=> (left == $past(left) - 32'($countones($past(mem_be)))));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pkg_done |=> !pkg_done);

  assert_stop_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (!mem_req && !pkg_done));

  assert_hold_dst_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && d_cfg.hold_addr && !stop_evt) |=> $stable(dst_a));

  assert_end_idles_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pkg_done && chain_end && !stop_evt && !ctl_we) |=> !run_o);

  assert_gate_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_GATE) && !side_ready && !stop_evt) |=> !mem_req);
endmodule

// File: tb/dlc_chan_top_tb_top.sv
`timescale 1ns/1ps
module dlc_chan_top_tb_top;
  localparam logic [31:0] ENDM = 32'hFFFF_F800;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        ctl_we = 1'b0, ctl_sel = 1'b0;
  logic [31:0] ctl_wdata = '0;
  logic        src_rdy = 1'b0, dst_rdy = 1'b0;
  logic        mem_req, mem_we, mem_gnt, pkg_done, run_o;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic [31:0] mem_addr, mem_wdata, cur_src_o, cur_dst_o, bytes_left_o;
  logic [3:0]  mem_be;

  dlc_chan_top dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_sel(ctl_sel), .ctl_wdata(ctl_wdata),
    .src_rdy(src_rdy), .dst_rdy(dst_rdy), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_gnt(mem_gnt),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .pkg_done(pkg_done), .run_o(run_o),
    .cur_src_o(cur_src_o), .cur_dst_o(cur_dst_o), .bytes_left_o(bytes_left_o)
  );

  // ---------------- memory model ----------------
  logic [31:0] mem [0:255];
  logic        gnt_stall = 1'b0;
  logic [1:0]  stall_ph = 2'd0;
  int          cyc = 0, rd_n = 0, wr_n = 0, done_n = 0;
  int          rd_cyc [0:63];
  int          wr_cyc [0:63];
  logic [31:0] rd_adr [0:63];
  int          n_chk = 0, n_err = 0;

  assign mem_gnt = !gnt_stall || (stall_ph == 2'd0);

  always @(posedge clk) begin
    cyc        <= cyc + 1;
    stall_ph   <= (stall_ph == 2'd2) ? 2'd0 : stall_ph + 2'd1;
    mem_rvalid <= 1'b0;
    if (rst_n && mem_req && mem_gnt) begin
      if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem[mem_addr[9:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
        wr_cyc[wr_n % 64] <= cyc;
        wr_n <= wr_n + 1;
      end else begin
        mem_rdata  <= mem[mem_addr[9:2]];
        mem_rvalid <= 1'b1;
        rd_cyc[rd_n % 64] <= cyc;
        rd_adr[rd_n % 64] <= mem_addr;
        rd_n <= rd_n + 1;
      end
    end
  end

  always @(negedge clk) if (pkg_done) done_n <= done_n + 1;

  // ---------------- helpers ----------------
  function automatic logic [7:0] get_b(input int a);
    return mem[a >> 2][8*(a % 4) +: 8];
  endfunction

  function automatic logic [31:0] mk_cfg(input int dw, input int db, input int dh, input int dk,
                                         input int sw, input int sb, input int sh, input int sk);
    return (32'(dw) << 25) | (32'(db) << 22) | (32'(dh) << 21) | (32'(dk) << 16) |
           (32'(sw) << 9)  | (32'(sb) << 6)  | (32'(sh) << 5)  | 32'(sk);
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic reg_write(input logic sel, input logic [31:0] d);
    @(negedge clk);
    ctl_we = 1'b1; ctl_sel = sel; ctl_wdata = d;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic put_desc(input int at, input logic [31:0] c, input logic [31:0] s,
                          input logic [31:0] d, input logic [31:0] n, input logic [31:0] p,
                          input logic [31:0] nx);
    mem[at/4 + 0] <= c;  mem[at/4 + 1] <= s;  mem[at/4 + 2] <= d;
    mem[at/4 + 3] <= n;  mem[at/4 + 4] <= p;  mem[at/4 + 5] <= nx;
    @(negedge clk);
  endtask

  task automatic start_at(input logic [31:0] a);
    reg_write(1'b1, a);
    reg_write(1'b0, 32'd1);
  endtask

  task automatic wait_idle(input string req);
    int t;
    t = 0;
    while (run_o && t < 4000) begin
      @(negedge clk);
      t++;
    end
    chk(req, "channel returned to idle", {31'd0, run_o}, 32'd0);
  endtask

  task automatic cmp_bytes(input string req, input int s, input int d, input int n);
    for (int i = 0; i < n; i++)
      chk(req, $sformatf("byte at %0h", d + i), {24'd0, get_b(d + i)}, {24'd0, get_b(s + i)});
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset;
    chk("R1", "run after reset", {31'd0, run_o}, 32'd0);
    chk("R1", "req after reset", {31'd0, mem_req}, 32'd0);
    chk("R1", "done after reset", {31'd0, pkg_done}, 32'd0);
    chk("R1", "src status", cur_src_o, 32'd0);
    chk("R1", "dst status", cur_dst_o, 32'd0);
    chk("R1", "left status", bytes_left_o, 32'd0);
  endtask

  task automatic t_basic;
    int rb, wb, db;
    logic [31:0] after;
    after = mem[32'h210 >> 2];
    rb = rd_n; wb = wr_n; db = done_n;
    put_desc(32'h000, mk_cfg(3, 1, 0, 0, 3, 1, 0, 0), 32'h100, 32'h200, 32'd16, 32'd0, ENDM);
    start_at(32'h000);
    chk("R2", "run raised by start", {31'd0, run_o}, 32'd1);
    wait_idle("R10");
    for (int i = 0; i < 6; i++)
      chk("R2", $sformatf("fetch address %0d", i), rd_adr[(rb + i) % 64], 32'(4 * i));
    cmp_bytes("R2", 32'h100, 32'h200, 16);
    chk("R2", "word past end untouched", mem[32'h210 >> 2], after);
    chk("R3", "8-byte code runs as 4-byte beats", 32'(wr_n - wb), 32'd4);
    chk("R9", "one done pulse", 32'(done_n - db), 32'd1);
    chk("R13", "final src", cur_src_o, 32'h110);
    chk("R13", "final dst", cur_dst_o, 32'h210);
    chk("R13", "final left", bytes_left_o, 32'd0);
  endtask

  task automatic t_lanes;
    int wb;
    logic [7:0] lo, hi;
    lo = get_b(32'h241); hi = get_b(32'h247);
    wb = wr_n;
    put_desc(32'h020, mk_cfg(0, 0, 0, 0, 0, 0, 0, 0), 32'h121, 32'h242, 32'd5, 32'd0, ENDM);
    start_at(32'h020);
    wait_idle("R5");
    cmp_bytes("R5", 32'h121, 32'h242, 5);
    chk("R5", "byte below untouched", {24'd0, get_b(32'h241)}, {24'd0, lo});
    chk("R5", "byte above untouched", {24'd0, get_b(32'h247)}, {24'd0, hi});
    chk("R3", "byte elements give five writes", 32'(wr_n - wb), 32'd5);
  endtask

  task automatic t_tail;
    int wb;
    logic [7:0] a, b;
    a = get_b(32'h28A); b = get_b(32'h28B);
    wb = wr_n;
    put_desc(32'h040, mk_cfg(2, 2, 0, 0, 2, 2, 0, 0), 32'h140, 32'h280, 32'd10, 32'd0, ENDM);
    start_at(32'h040);
    wait_idle("R6");
    cmp_bytes("R6", 32'h140, 32'h280, 10);
    chk("R6", "tail byte 10 untouched", {24'd0, get_b(32'h28A)}, {24'd0, a});
    chk("R6", "tail byte 11 untouched", {24'd0, get_b(32'h28B)}, {24'd0, b});
    chk("R6", "three writes", 32'(wr_n - wb), 32'd3);
  endtask

  task automatic t_hold;
    int wb;
    logic [7:0] c2, c3;
    c2 = get_b(32'h2C2); c3 = get_b(32'h2C3);
    wb = wr_n;
    put_desc(32'h060, mk_cfg(1, 0, 1, 0, 2, 0, 0, 0), 32'h160, 32'h2C0, 32'd6, 32'd0, ENDM);
    start_at(32'h060);
    wait_idle("R4");
    chk("R3", "halfword elements give three writes", 32'(wr_n - wb), 32'd3);
    chk("R4", "held dst low byte = last halfword", {24'd0, get_b(32'h2C0)}, {24'd0, get_b(32'h164)});
    chk("R4", "held dst byte 1", {24'd0, get_b(32'h2C1)}, {24'd0, get_b(32'h165)});
    chk("R4", "held dst byte 2 untouched", {24'd0, get_b(32'h2C2)}, {24'd0, c2});
    chk("R4", "held dst byte 3 untouched", {24'd0, get_b(32'h2C3)}, {24'd0, c3});
    chk("R4", "held dst address", cur_dst_o, 32'h2C0);
    chk("R4", "linear src address", cur_src_o, 32'h166);
  endtask

  task automatic t_bursts;
    int rb, wb;
    rb = rd_n; wb = wr_n;
    put_desc(32'h080, mk_cfg(2, 1, 0, 0, 2, 1, 0, 0), 32'h180, 32'h300, 32'd32, 32'd2, ENDM);
    start_at(32'h080);
    wait_idle("R7");
    cmp_bytes("R7", 32'h180, 32'h300, 32);
    chk("R7", "gap inside burst k1", 32'(rd_cyc[(rb + 7) % 64] - wr_cyc[(wb + 0) % 64]), 32'd1);
    chk("R7", "gap inside burst k3", 32'(rd_cyc[(rb + 9) % 64] - wr_cyc[(wb + 2) % 64]), 32'd1);
    chk("R7", "gap between bursts W+2", 32'(rd_cyc[(rb + 10) % 64] - wr_cyc[(wb + 3) % 64]), 32'd4);
    chk("R7", "gap inside second burst", 32'(rd_cyc[(rb + 11) % 64] - wr_cyc[(wb + 4) % 64]), 32'd1);
  endtask

  task automatic t_chain;
    int rb, wb, db;
    rb = rd_n; wb = wr_n; db = done_n;
    put_desc(32'h0A0, mk_cfg(2, 0, 0, 0, 2, 0, 0, 0), 32'h1C0, 32'h340, 32'd0, 32'd0, 32'h0C0);
    put_desc(32'h0C0, mk_cfg(2, 0, 0, 0, 2, 0, 0, 0), 32'h1C0, 32'h340, 32'd8, 32'd0, ENDM);
    start_at(32'h0A0);
    wait_idle("R10");
    chk("R9", "two done pulses", 32'(done_n - db), 32'd2);
    chk("R9", "zero count makes no data read", 32'(rd_n - rb), 32'd14);
    chk("R9", "writes only from second descriptor", 32'(wr_n - wb), 32'd2);
    chk("R10", "next descriptor fetched", rd_adr[(rb + 6) % 64], 32'h0C0);
    cmp_bytes("R10", 32'h1C0, 32'h340, 8);
  endtask

  task automatic t_ready;
    int rb, wb;
    rb = rd_n; wb = wr_n;
    src_rdy = 1'b0;
    put_desc(32'h0E0, mk_cfg(2, 0, 0, 0, 2, 0, 0, 3), 32'h1D0, 32'h360, 32'd8, 32'd0, ENDM);
    start_at(32'h0E0);
    repeat (40) @(negedge clk);
    chk("R8", "only descriptor reads while not ready", 32'(rd_n - rb), 32'd6);
    chk("R8", "no writes while not ready", 32'(wr_n - wb), 32'd0);
    chk("R8", "still running", {31'd0, run_o}, 32'd1);
    src_rdy = 1'b1;
    wait_idle("R8");
    cmp_bytes("R8", 32'h1D0, 32'h360, 8);
    src_rdy = 1'b0;
  endtask

  task automatic t_stop;
    int wb, w1, db;
    wb = wr_n;
    put_desc(32'h100 - 32'h20, mk_cfg(2, 0, 0, 0, 2, 0, 0, 0), 32'h100, 32'h380, 32'd64, 32'd30, ENDM);
    db = done_n;
    start_at(32'h0E0);
    repeat (80) @(negedge clk);
    reg_write(1'b0, 32'd0);
    chk("R11", "run low after stop", {31'd0, run_o}, 32'd0);
    chk("R11", "no request after stop", {31'd0, mem_req}, 32'd0);
    w1 = wr_n;
    chk("R13", "src progress matches count", cur_src_o - 32'h100, 32'd64 - bytes_left_o);
    chk("R13", "dst progress matches count", cur_dst_o - 32'h380, 32'd64 - bytes_left_o);
    chk("R13", "progress equals writes", cur_dst_o - 32'h380, 32'(4 * (w1 - wb)));
    repeat (60) @(negedge clk);
    chk("R11", "no writes after stop", 32'(wr_n - w1), 32'd0);
    chk("R11", "no done after stop", 32'(done_n - db), 32'd0);
  endtask

  task automatic t_stall;
    int rb, wb;
    rb = rd_n; wb = wr_n;
    gnt_stall = 1'b1;
    put_desc(32'h0A0, mk_cfg(2, 0, 0, 0, 2, 0, 0, 0), 32'h110, 32'h3D0, 32'd12, 32'd0, ENDM);
    start_at(32'h0A0);
    wait_idle("R12");
    cmp_bytes("R12", 32'h110, 32'h3D0, 12);
    chk("R12", "no repeated reads", 32'(rd_n - rb), 32'd9);
    chk("R12", "no repeated writes", 32'(wr_n - wb), 32'd3);
    gnt_stall = 1'b0;
  endtask

  // ---------------- sequence ----------------
  initial begin
    for (int i = 0; i < 256; i++) mem[i] <= 32'h5A00_0000 ^ (32'(i) * 32'h0103_0507);
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_basic;
    t_lanes;
    t_tail;
    t_hold;
    t_bursts;
    t_chain;
    t_ready;
    t_stop;
    t_stall;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule